// File: doc/BRIEF.md
# Four-to-two carry-save compressor

This block takes four unsigned operands of equal width and reduces them to two rows, a sum vector and a carry vector, whose arithmetic sum equals the sum of the four operands. It is meant to sit in front of a single carry-propagate adder, or to feed a larger reduction tree, wherever four numbers must be added with the delay of only a few gate levels.

Each bit column holds two full adders in series. The first adds three operand bits of the column. Its carry goes straight to the next column up, so that carry depends on the column's own operand bits and nothing else. The second full adder combines the first adder's sum, the fourth operand bit and the forwarded carry from the column below. It produces the sum-vector bit of the column and a carry-vector bit one weight higher. No signal passes through more than one column, so the delay is the same for every width.

The block has no clock and no storage. Both outputs are one bit wider than the operands. Bit 0 of the carry vector is always zero.

Top module: `c42_compressor`

## Requirements
- R1: For every input combination, `sum_vec + carry_vec` equals `opa + opb + opc + opd`, computed without loss at WIDTH+2 bits.
- R2: `carry_vec[0]` is 0 for every input.
- R3: Define the forwarded carry f[i] as the majority of opa[i], opb[i] and opc[i], with f[-1] = 0. Then `sum_vec[i]` for i < WIDTH equals the parity of opa[i], opb[i], opc[i], opd[i] and f[i-1].
- R4: `sum_vec[WIDTH]` equals f[WIDTH-1], the forwarded carry of the top column.
- R5: For i < WIDTH, `carry_vec[i+1]` equals the majority of (opa[i] xor opb[i] xor opc[i]), opd[i] and f[i-1].
- R6: The outputs follow any change at the inputs without a clock edge.
- R7: When all four operands are all ones, the outputs carry the full total 4*(2^WIDTH-1) and drop no carry.
- R8: When all operands are zero, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| opc | input | WIDTH | Third operand |
| opd | input | WIDTH | Fourth operand, enters at the second adder level |
| sum_vec | output | WIDTH+1 | Sum row; top bit is the forwarded carry of the top column |
| carry_vec | output | WIDTH+1 | Carry row, weighted one column up; bit 0 is zero |

## Verification
The hardest case to reach is a column whose second full adder sees all three of its inputs at 1: the first adder's sum, the fourth operand bit and a forwarded carry from below. Both carry paths fire at once there, and if any bit of weight is lost it shows up only in that column. The stimulus table therefore holds patterns that put three or more ones in the lower column's first three operands and an odd count in the current column. Examples are all-ones operands and alternating bit masks shifted by one position between operands. Random vectors then cover the mixed cases, and every result is checked bit by bit against the column equations.

// File: rtl/c42_pkg.sv
package c42_pkg;

  // Operands consumed per column by the reduction
  localparam int unsigned OPS_PER_COL = 4;

  // Bits produced by one column: sum bit, carry-vector bit, forwarded carry
  typedef struct packed {
    logic fwd;
    logic cbit;
    logic sbit;
  } col_out_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (z & (x ^ y));
  endfunction

endpackage

// File: rtl/c42_fa_cell.sv
module c42_fa_cell
  import c42_pkg::*;
(
  input  logic in_x,
  input  logic in_y,
  input  logic in_z,
  output logic sum_o,
  output logic carry_o
);

  assign sum_o   = fa_sum(in_x, in_y, in_z);
  assign carry_o = fa_carry(in_x, in_y, in_z);

  // R1: a single cell keeps the weight of its three inputs
  always_comb begin
    a_r1_cell_weight: assert ({carry_o, sum_o} ==
                              (2'(in_x) + 2'(in_y) + 2'(in_z)))
      else $error("full adder cell lost weight");
  end

endmodule

// File: rtl/c42_column.sv
module c42_column
  import c42_pkg::*;
(
  input  logic [OPS_PER_COL-1:0] col_bits,
  input  logic                   fwd_in,
  output col_out_t               col_res
);

  logic lvl1_sum;   // first-level sum, enters the second adder
  logic lvl1_fwd;   // first-level carry, leaves toward the next column
  logic lvl2_sum;
  logic lvl2_carry;

  c42_fa_cell u_lvl1 (
    .in_x   (col_bits[0]),
    .in_y   (col_bits[1]),
    .in_z   (col_bits[2]),
    .sum_o  (lvl1_sum),
    .carry_o(lvl1_fwd)
  );

  c42_fa_cell u_lvl2 (
    .in_x   (lvl1_sum),
    .in_y   (col_bits[3]),
    .in_z   (fwd_in),
    .sum_o  (lvl2_sum),
    .carry_o(lvl2_carry)
  );

  assign col_res.sbit = lvl2_sum;
  assign col_res.cbit = lvl2_carry;
  assign col_res.fwd  = lvl1_fwd;

  // R1: five inputs of weight 1 equal sum bit plus two outgoing bits of weight 2
  always_comb begin
    a_r1_column_weight: assert (
      (3'(col_bits[0]) + 3'(col_bits[1]) + 3'(col_bits[2]) +
       3'(col_bits[3]) + 3'(fwd_in)) ==
      (3'(col_res.sbit) + 3'({col_res.cbit, 1'b0}) + 3'({col_res.fwd, 1'b0})))
      else $error("column lost weight");
  end

  // R3: the sum bit is the parity of all five column inputs
  always_comb begin
    a_r3_sum_parity: assert (col_res.sbit == ^{col_bits, fwd_in})
      else $error("column sum bit is not the input parity");
  end

endmodule

// File: rtl/c42_compressor.sv
module c42_compressor
  import c42_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] opc,
  input  logic [WIDTH-1:0] opd,
  output logic [WIDTH:0]   sum_vec,
  output logic [WIDTH:0]   carry_vec
);

  localparam int unsigned OUT_W = WIDTH + 1;
  localparam int unsigned TOT_W = WIDTH + 2;

  // fwd_chain[i] is the forwarded carry entering column i
  logic [WIDTH:0]  fwd_chain;
  col_out_t        col_res [WIDTH];
  logic [TOT_W-1:0] total_in;
  logic [TOT_W-1:0] total_out;

  assign fwd_chain[0] = 1'b0;
  assign carry_vec[0] = 1'b0;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_col
    c42_column u_col (
      .col_bits({opd[gi], opc[gi], opb[gi], opa[gi]}),
      .fwd_in  (fwd_chain[gi]),
      .col_res (col_res[gi])
    );
    assign fwd_chain[gi+1] = col_res[gi].fwd;
    assign sum_vec[gi]     = col_res[gi].sbit;
    assign carry_vec[gi+1] = col_res[gi].cbit;
  end

  assign sum_vec[WIDTH] = fwd_chain[WIDTH];

  // Named totals exposed for the row-level check
  assign total_in  = TOT_W'(opa) + TOT_W'(opb) + TOT_W'(opc) + TOT_W'(opd);
  assign total_out = TOT_W'(sum_vec) + TOT_W'(carry_vec);

  // R1: the two output rows carry exactly the sum of the four operands
  always_comb begin
    a_r1_rows_total: assert (total_out == total_in)
      else $error("output rows do not sum to the operand total");
  end

  // R8: zero operands give zero rows
  always_comb begin
    a_r8_zero_rows: assert (!((opa | opb | opc | opd) == '0) ||
                            ((sum_vec | carry_vec) == OUT_W'(0)))
      else $error("nonzero rows for zero operands");
  end

endmodule

// File: tb/c42_compressor_test.sv
module c42_compressor_test;

  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [W-1:0] opa, opb, opc, opd;
  logic [W:0]   sum_vec, carry_vec;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  c42_compressor #(.WIDTH(W)) uut (
    .opa(opa), .opb(opb), .opc(opc), .opd(opd),
    .sum_vec(sum_vec), .carry_vec(carry_vec)
  );

  // Stimulus table: {opa, opb, opc, opd}
  localparam logic [31:0] VEC [12] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0101_0101, 32'h8080_8080,
    32'hAA55_AA55, 32'hAAAA_AA00, 32'h5555_55FF, 32'hFF00_FF00,
    32'h7F7F_7F7F, 32'h0102_0408, 32'hCCCC_CC33, 32'hFFFF_FF00
  };

  function automatic logic maj(input logic x, input logic y, input logic z);
    return (x && y) || (x && z) || (y && z);
  endfunction

  // Expected rows from the column equations of R2..R5
  task automatic model(input logic [W-1:0] a, b, c, d,
                       output logic [W:0] es, output logic [W:0] ec);
    logic f_prev;
    f_prev = 1'b0;
    es = '0;
    ec = '0;
    for (int i = 0; i < W; i++) begin
      logic p;
      p = a[i] ^ b[i] ^ c[i];
      es[i]   = p ^ d[i] ^ f_prev;
      ec[i+1] = maj(p, d[i], f_prev);
      f_prev  = maj(a[i], b[i], c[i]);
    end
    es[W] = f_prev;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h c=%h d=%h)",
               req, act, exp_v, opa, opb, opc, opd);
    end
  endtask

  task automatic apply_and_check(input logic [W-1:0] a, b, c, d);
    logic [W:0] es, ec;
    @(posedge clk);
    opa = a; opb = b; opc = c; opd = d;
    @(negedge clk);
    model(a, b, c, d, es, ec);
    check("R1 total", 32'(sum_vec) + 32'(carry_vec), 32'(a) + 32'(b) + 32'(c) + 32'(d));
    check("R2 carry lsb", 32'(carry_vec[0]), 32'd0);
    check("R3 sum bits", 32'(sum_vec[W-1:0]), 32'(es[W-1:0]));
    check("R4 sum top", 32'(sum_vec[W]), 32'(es[W]));
    check("R5 carry bits", 32'(carry_vec), 32'(ec));
  endtask

  initial begin
    opa = '0; opb = '0; opc = '0; opd = '0;
    repeat (2) @(posedge clk);

    // R8: zero operands
    @(negedge clk);
    check("R8 zero sum", 32'(sum_vec), 32'd0);
    check("R8 zero carry", 32'(carry_vec), 32'd0);

    // Table walk
    for (int k = 0; k < 12; k++)
      apply_and_check(VEC[k][31:24], VEC[k][23:16], VEC[k][15:8], VEC[k][7:0]);

    // R7: all-ones reaches the maximum total
    apply_and_check({W{1'b1}}, {W{1'b1}}, {W{1'b1}}, {W{1'b1}});
    check("R7 max total", 32'(sum_vec) + 32'(carry_vec), 32'(4 * ((1 << W) - 1)));

    // R6: outputs follow inputs with no clock edge in between
    @(negedge clk);
    opa = 8'h0F; opb = 8'hF0; opc = 8'h33; opd = 8'hC3;
    #2;
    check("R6 comb total", 32'(sum_vec) + 32'(carry_vec), 32'(8'h0F) + 32'(8'hF0) + 32'(8'h33) + 32'(8'hC3));
    opd = 8'h01;
    #2;
    check("R6 comb update", 32'(sum_vec) + 32'(carry_vec), 32'(8'h0F) + 32'(8'hF0) + 32'(8'h33) + 32'(8'h01));

    // Random vectors
    for (int k = 0; k < 300; k++)
      apply_and_check(W'($urandom), W'($urandom), W'($urandom), W'($urandom));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule